// File: doc/BRIEF.md
# I2C Serial Memory Write Receiver

This block is the target-side receive path for writes into a 2K x 8 serial memory reached over I2C. It samples the bus clock and data lines with the system clock, finds START and STOP conditions, and shifts in bytes MSB first. The first byte after a START is a control byte. Its upper four bits are a device code, the next three bits select one of eight 256-byte blocks, and the lowest bit gives the direction. The block acknowledges a control byte only if the code matches, the direction is write, and the memory is not busy with an internal write.

Once a control byte is accepted, the next byte is loaded into the word pointer. Each later byte is a data byte. Each one is handed to a downstream write buffer as a one-cycle strobe, together with an 11-bit address made of the three block bits followed by the pointer. The low four pointer bits then advance and wrap within a 16-byte page. A STOP that ends a transfer carrying data raises a one-cycle commit strobe, which starts the downstream write cycle. Read transfers, clock stretching and the pad itself are handled elsewhere. The block pulls the data line low by raising an output enable.

Top module: `i2c_wr_front`

## Requirements
- R1: While reset is held, and directly after it, `sda_oe`, `wr_valid` and `wr_commit` are low.
- R2: A control byte with bits [7:4] = 4'b1010 and bit [0] = 0, received while `busy_i` is low, is acknowledged: `sda_oe` is high during the ninth SCL high period of that byte.
- R3: A control byte whose bits [7:4] differ from 4'b1010, or whose bit [0] is 1, is not acknowledged. Every later byte up to the next START is also not acknowledged and produces no `wr_valid`.
- R4: A control byte received while `busy_i` is high is not acknowledged, and the transfer produces no write or commit.
- R5: After an accepted control byte, the word-address byte and every data byte are acknowledged on their ninth clock.
- R6: Each data byte produces exactly one single-cycle `wr_valid` pulse, with `wr_data` equal to the byte and `wr_addr` = {control bits [3:1], pointer}.
- R7: The first data byte uses the received word address as its pointer. After each data byte, pointer bits [3:0] increment modulo 16 while bits [7:4] and the block bits stay constant.
- R8: A STOP that follows at least one data byte gives one single-cycle `wr_commit` pulse. A STOP with no data byte in the transfer gives none.
- R9: A repeated START at any bit position discards the partly received byte and restarts control-byte reception. The discarded byte causes no write, and the transfer interrupted this way causes no commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| busy_i | input | 1 | Internal write cycle in progress |
| sda_oe | output | 1 | High to pull the data line low (acknowledge) |
| wr_valid | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | 11 | Memory address of the data byte |
| wr_data | output | 8 | Received data byte |
| wr_commit | output | 1 | One-cycle strobe on STOP after data |

## Verification
Accepted transfers are driven with random block selects, random word addresses and lengths of 1 to 20 bytes. Lengths above 16 and start addresses near the top of a page separate correct in-page wrap from linear increment or a carry into the upper pointer bits. Control bytes with a wrong code, with the read bit set, or sent while busy show whether refusal depends on all three fields and whether later bytes stay ignored. A STOP sent straight after the word address, and repeated STARTs placed in the middle of a byte, tell apart a commit that depends on data from one raised on every STOP, and show whether a partial byte is flushed.

// File: rtl/i2c_wr_front_pkg.sv
package i2c_wr_front_pkg;
  localparam int BYTE_W  = 8;
  localparam int CODE_W  = 4;
  localparam int BLK_W   = 3;
  localparam int WORD_W  = 8;
  localparam int ADDR_W  = BLK_W + WORD_W;
  localparam int BITCNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {
    FE_IDLE  = 2'd0,
    FE_CTRL  = 2'd1,
    FE_WADDR = 2'd2,
    FE_DATA  = 2'd3
  } fe_state_t;
endpackage

// File: rtl/fe_line_sync.sv
module fe_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic scl_cur;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_ff[STAGES-1];
      sda_q <= sda_ff[STAGES-1];
    end
  end

  assign scl_cur   = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_cur & ~scl_q;
  assign scl_fall  = ~scl_cur & scl_q;
  assign start_det = scl_cur & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_cur & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/fe_byte_rx.sv
module fe_byte_rx
  import i2c_wr_front_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              ack_slot,
  output logic              ack_end
);
  logic [BYTE_W-2:0]   shreg_q, shreg_n;
  logic [BITCNT_W-1:0] cnt_q, cnt_n;
  logic                slot_q, slot_n;

  assign byte_done = scl_rise & ~slot_q & (cnt_q == BITCNT_W'(BYTE_W - 1));
  assign byte_val  = {shreg_q, sda_s};
  assign ack_slot  = slot_q;
  assign ack_end   = scl_fall & slot_q;

  always_comb begin
    shreg_n = shreg_q;
    cnt_n   = cnt_q;
    slot_n  = slot_q;
    if (start_det || stop_det) begin
      cnt_n  = '0;
      slot_n = 1'b0;
    end else if (scl_rise && !slot_q && cnt_q < BITCNT_W'(BYTE_W)) begin
      shreg_n = byte_val[BYTE_W-2:0];
      cnt_n   = cnt_q + 1'b1;
    end else if (scl_fall && slot_q) begin
      slot_n = 1'b0;
    end else if (scl_fall && cnt_q == BITCNT_W'(BYTE_W)) begin
      slot_n = 1'b1;
      cnt_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      slot_q  <= 1'b0;
    end else begin
      shreg_q <= shreg_n;
      cnt_q   <= cnt_n;
      slot_q  <= slot_n;
    end
  end
endmodule

// File: rtl/fe_wr_ctrl.sv
module fe_wr_ctrl
  import i2c_wr_front_pkg::*;
#(
  parameter logic [CODE_W-1:0] DEV_CODE = 4'b1010,
  parameter int                PAGE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              ack_end,
  input  logic              busy_i,
  output logic              ack_pend,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_commit
);
  fe_state_t           state_q, state_n;
  logic [BLK_W-1:0]    blk_q, blk_n;
  logic [WORD_W-1:0]   ptr_q, ptr_n;
  logic                seen_q, seen_n;
  logic                ack_q, ack_n;
  logic                val_n, com_n;
  logic [ADDR_W-1:0]   addr_n;
  logic [BYTE_W-1:0]   data_n;
  logic                ctrl_ok;
  logic [PAGE_W-1:0]   page_lo;

  assign ctrl_ok = (byte_val[BYTE_W-1 -: CODE_W] == DEV_CODE) &&
                   !byte_val[0] && !busy_i;
  assign page_lo = ptr_q[PAGE_W-1:0] + PAGE_W'(1);

  always_comb begin
    state_n = state_q;
    blk_n   = blk_q;
    ptr_n   = ptr_q;
    seen_n  = seen_q;
    ack_n   = ack_q;
    val_n   = 1'b0;
    com_n   = 1'b0;
    addr_n  = wr_addr;
    data_n  = wr_data;
    if (ack_end) ack_n = 1'b0;
    if (start_det) begin
      state_n = FE_CTRL;
      seen_n  = 1'b0;
      ack_n   = 1'b0;
    end else if (stop_det) begin
      com_n   = (state_q == FE_DATA) && seen_q;
      state_n = FE_IDLE;
      seen_n  = 1'b0;
      ack_n   = 1'b0;
    end else if (byte_done) begin
      unique case (state_q)
        FE_CTRL: begin
          if (ctrl_ok) begin
            blk_n   = byte_val[BLK_W:1];
            ack_n   = 1'b1;
            state_n = FE_WADDR;
          end else begin
            state_n = FE_IDLE;
          end
        end
        FE_WADDR: begin
          ptr_n   = byte_val;
          ack_n   = 1'b1;
          state_n = FE_DATA;
        end
        FE_DATA: begin
          val_n  = 1'b1;
          addr_n = {blk_q, ptr_q};
          data_n = byte_val;
          ptr_n  = {ptr_q[WORD_W-1:PAGE_W], page_lo};
          ack_n  = 1'b1;
          seen_n = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= FE_IDLE;
      blk_q     <= '0;
      ptr_q     <= '0;
      seen_q    <= 1'b0;
      ack_q     <= 1'b0;
      wr_valid  <= 1'b0;
      wr_commit <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      state_q   <= state_n;
      blk_q     <= blk_n;
      ptr_q     <= ptr_n;
      seen_q    <= seen_n;
      ack_q     <= ack_n;
      wr_valid  <= val_n;
      wr_commit <= com_n;
      wr_addr   <= addr_n;
      wr_data   <= data_n;
    end
  end

  assign ack_pend = ack_q;
endmodule

// File: rtl/i2c_wr_front.sv
module i2c_wr_front
  import i2c_wr_front_pkg::*;
#(
  parameter logic [CODE_W-1:0] DEV_CODE    = 4'b1010,
  parameter int                SYNC_STAGES = 2,
  parameter int                PAGE_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              busy_i,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_commit
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic byte_done, ack_slot, ack_end, ack_pend;
  logic [BYTE_W-1:0] byte_val;

  fe_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  fe_byte_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .byte_done(byte_done), .byte_val(byte_val),
    .ack_slot(ack_slot), .ack_end(ack_end)
  );

  fe_wr_ctrl #(.DEV_CODE(DEV_CODE), .PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .byte_done(byte_done), .byte_val(byte_val), .ack_end(ack_end),
    .busy_i(busy_i), .ack_pend(ack_pend), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
  );

  assign sda_oe = ack_pend & ack_slot;
endmodule

// File: rtl/i2c_wr_front_chk.sv
module i2c_wr_front_chk
  import i2c_wr_front_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_i,
  input logic              sda_oe,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_commit,
  input logic              start_det,
  input logic              byte_done,
  input logic [BYTE_W-1:0] byte_val,
  input fe_state_t         ctrl_state,
  input logic              ack_pend
);
  logic              have_prev;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else if (start_det) begin
      have_prev <= 1'b0;
    end else if (wr_valid) begin
      have_prev <= 1'b1;
      prev_addr <= wr_addr;
    end
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!sda_oe && !wr_valid && !wr_commit)
        else $error("reset outputs not quiet");
    end
  end

  p_busy_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_state == FE_CTRL && byte_done && busy_i) |=> !ack_pend);

  p_read_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_state == FE_CTRL && byte_done && byte_val[0]) |=> !ack_pend);

  p_idle_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_state == FE_IDLE) |=> !wr_valid);

  p_wr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  p_page_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && have_prev) |->
      (wr_addr[ADDR_W-1:PAGE_W] == prev_addr[ADDR_W-1:PAGE_W] &&
       wr_addr[PAGE_W-1:0] == prev_addr[PAGE_W-1:0] + PAGE_W'(1)));

  p_commit_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  p_ack_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |=> sda_oe);
endmodule

bind i2c_wr_front i2c_wr_front_chk #(.PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .sda_oe(sda_oe),
  .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_commit(wr_commit),
  .start_det(start_det), .byte_done(byte_done), .byte_val(byte_val),
  .ctrl_state(u_ctrl.state_q), .ack_pend(ack_pend)
);

// File: tb/i2c_wr_front_tb.sv
module i2c_wr_front_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int MAXW = 2048;

  logic clk, rst_n, scl_m, sda_m, busy_i;
  logic sda_line;
  logic sda_oe, wr_valid, wr_commit;
  logic [10:0] wr_addr;
  logic [7:0]  wr_data;

  int n_run, n_fail, n_got, n_com;
  logic [10:0] got_addr [MAXW];
  logic [7:0]  got_data [MAXW];
  logic [10:0] exp_a [MAXW];
  logic [7:0]  exp_d [MAXW];
  bit done;

  assign sda_line = sda_m & ~sda_oe;

  i2c_wr_front u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .busy_i(busy_i), .sda_oe(sda_oe), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && wr_valid && n_got < MAXW) begin
      got_addr[n_got] = wr_addr;
      got_data[n_got] = wr_data;
      n_got = n_got + 1;
    end
    if (rst_n && wr_commit) n_com = n_com + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_addr(input logic [2:0] blk,
                                           input logic [7:0] wa, input int i);
    logic [3:0] lo;
    lo = wa[3:0] + 4'(i);
    return {blk, wa[7:4], lo};
  endfunction

  task automatic step();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; step(); scl_m = 1'b1; step();
    sda_m = 1'b0; step(); scl_m = 1'b0; step();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; step(); scl_m = 1'b1; step(); sda_m = 1'b1; step();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; step(); scl_m = 1'b1; step(); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; step(); scl_m = 1'b1;
    repeat (HALF/2) @(negedge clk);
    acked = (sda_line == 1'b0);
    repeat (HALF - HALF/2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  // full write transfer; checks ACKs, writes and commit
  task automatic write_xfer(input logic [2:0] blk, input logic [7:0] wa,
                            input int len, input string tag);
    bit a;
    int base, cbase, acks;
    base = n_got; cbase = n_com; acks = 0;
    bus_start();
    send_byte({4'b1010, blk, 1'b0}, a);
    chk({tag, " R2 ctrl ack"}, int'(a), 1);
    send_byte(wa, a);
    chk({tag, " R5 waddr ack"}, int'(a), 1);
    for (int i = 0; i < len; i++) begin
      exp_a[i] = exp_addr(blk, wa, i);
      exp_d[i] = 8'($urandom);
      send_byte(exp_d[i], a);
      acks += int'(a);
    end
    chk({tag, " R5 data acks"}, acks, len);
    bus_stop();
    repeat (4) @(negedge clk);
    chk({tag, " R6 write count"}, n_got - base, len);
    for (int i = 0; i < len; i++) begin
      chk({tag, " R7 addr"}, int'(got_addr[base+i]), int'(exp_a[i]));
      chk({tag, " R6 data"}, int'(got_data[base+i]), int'(exp_d[i]));
    end
    chk({tag, " R8 commit"}, n_com - cbase, len > 0 ? 1 : 0);
  endtask

  // refused control byte followed by bytes that must be ignored
  task automatic refused_xfer(input logic [7:0] ctrl, input string tag);
    bit a;
    int base, cbase, acks;
    base = n_got; cbase = n_com; acks = 0;
    bus_start();
    send_byte(ctrl, a);
    chk({tag, " ctrl no ack"}, int'(a), 0);
    for (int i = 0; i < 3; i++) begin
      send_byte(8'($urandom), a);
      acks += int'(a);
    end
    chk({tag, " later bytes no ack"}, acks, 0);
    bus_stop();
    repeat (4) @(negedge clk);
    chk({tag, " no writes"}, n_got - base, 0);
    chk({tag, " no commit"}, n_com - cbase, 0);
  endtask

  initial begin
    bit a;
    int base, cbase;
    void'($urandom(32'h1c2d));
    n_run = 0; n_fail = 0; n_got = 0; n_com = 0; done = 0;
    scl_m = 1'b1; sda_m = 1'b1; busy_i = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset sda_oe", int'(sda_oe), 0);
    chk("R1 reset wr_valid", int'(wr_valid), 0);
    chk("R1 reset wr_commit", int'(wr_commit), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after reset outputs", int'({sda_oe, wr_valid, wr_commit}), 0);

    // directed: single byte, wrap at page end, long wrap
    write_xfer(3'd5, 8'h3C, 1, "dir_single");
    write_xfer(3'd7, 8'hFE, 4, "dir_wrap_R7");
    write_xfer(3'd0, 8'h81, 20, "dir_long_R7");

    // R8: STOP right after word address, no commit
    cbase = n_com; base = n_got;
    bus_start(); send_byte(8'hA4, a); send_byte(8'h10, a); bus_stop();
    repeat (4) @(negedge clk);
    chk("R8 no-data stop commit", n_com - cbase, 0);
    chk("R8 no-data stop writes", n_got - base, 0);

    // R3: wrong device code, read bit set
    refused_xfer(8'hB2, "R3 wrong code");
    refused_xfer(8'hA3, "R3 read bit");

    // R4: busy
    busy_i = 1'b1;
    refused_xfer(8'hA6, "R4 busy");
    busy_i = 1'b0;

    // R9: repeated START mid-byte aborts, then new transfer
    cbase = n_com; base = n_got;
    bus_start(); send_byte(8'hA2, a); send_byte(8'h40, a);
    send_byte(8'h11, a); send_bits(8'hFF, 5);
    scl_m = 1'b0;
    bus_start();
    send_byte(8'hAC, a);
    chk("R9 ctrl after restart ack", int'(a), 1);
    send_byte(8'h20, a); send_byte(8'h77, a);
    bus_stop();
    repeat (4) @(negedge clk);
    chk("R9 writes (partial byte dropped)", n_got - base, 2);
    chk("R9 first addr", int'(got_addr[base]), int'(11'h140));
    chk("R9 second addr", int'(got_addr[base+1]), int'(11'h620));
    chk("R9 second data", int'(got_data[base+1]), 8'h77);
    chk("R9 single commit", n_com - cbase, 1);

    // R9: restart right inside the control byte
    cbase = n_com; base = n_got;
    bus_start(); send_bits(8'hA0, 3); scl_m = 1'b0;
    write_xfer(3'd1, 8'h0F, 2, "R9 restart_in_ctrl");

    // random transfers
    for (int t = 0; t < 20; t++) begin
      write_xfer(3'($urandom), 8'($urandom), 1 + int'($urandom_range(19)), "rand");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule